// File: doc/BRIEF.md
# Cluster performance request controller

This block is the register-mapped sequencer that a two-cluster processor system uses to change the operating point of each cluster. One cluster is the big cluster and one is the little cluster. Software writes a target performance index into a cluster's level register. The block holds that request for a fixed number of clock cycles, set by a parameter, that stands in for the settling time of the supply and clock. It then makes the new index the applied one and sets a completion flag. If the index is out of range, or a request is already in flight, the block sets an error flag instead. Any set flag drives a level-high interrupt. Reading the status word returns the flags and clears them.

Around the sequencer sit the registers that power management software uses next to it:
- a wake-up enable mask, with per-CPU bits and two global bits;
- one power-down enable bit per cluster;
- one 32-bit resume-address mailbox per CPU;
- a read-only word that reflects the per-CPU standby (wait-for-interrupt) input pins.

These values also leave the block as plain output pins. Voltage and clock switching themselves happen elsewhere.

The bus is a single-cycle register port. A cycle with `bus_en` high is one access, and `bus_we` selects write or read. Every access is taken at once: the port has no back-pressure. Read data comes back as a stream item on `bus_rdata`, qualified by `bus_rvalid`. It arrives exactly one cycle after the read and cannot be stalled, so the reader must take it in that cycle. Addresses are byte addresses of 32-bit words. `N_BIG` may be at most 3 and `N_LIT` at most 4, so that the bit layouts below fit.

Top module: `cpr_ctrl`

## Requirements
- R1: After reset, both applied levels, the status word, `irq`, the wake mask, both power-down bits and all mailboxes are zero.
- R2: A write to 0x00 (big) or 0x08 (little) while idle, with a data value below `NUM_LEVELS`, starts a request. Exactly `LAT_CYC` clock edges after the accepting edge, the applied level of that cluster takes the written index and its completion flag sets. The completion flag is bit 0 for big and bit 4 for little. Reading 0x00 or 0x08 returns the applied index, which keeps its old value until completion.
- R3: A level write whose full 32-bit data is at or above `NUM_LEVELS` sets that cluster's error flag on the accepting edge and leaves the applied level unchanged. The error flag is bit 1 for big and bit 5 for little.
- R4: A level write accepted while a request is in flight is ignored. This includes a write on the edge where the request completes. It sets the error flag of the written cluster on that edge, and the request in flight completes normally.
- R5: A read of the status word at 0x18 returns all flags and clears them. A flag that sets on the same edge survives the clear. `irq` is high exactly while any flag is set. Only bits 0, 1, 4 and 5 can ever be non-zero; lane 2 (bits 8 and 9), reserved for configuration requests, stays zero.
- R6: The wake mask at 0x24 stores big CPU n at bit n, little CPU n at bit 4+n and the two global enables at bits 10 and 11. All other bits read zero. The mask drives `wake_mask`.
- R7: The power-down enables at 0x30 (big) and 0x34 (little) keep only data bit 0, read back in bit 0, and drive `pdn_en_big` and `pdn_en_lit`.
- R8: The resume mailbox of big CPU n is at 0x68+4n and that of little CPU n is at 0x78+4n. Each holds a full 32-bit word and drives its slice of `resume_big` or `resume_lit`. A mailbox address beyond the CPU count reads zero.
- R9: The standby word at 0x3C shows `wfi_big[n]` at bit n and `wfi_lit[n]` at bit 3+n. It is read-only, and writes to it have no effect.
- R10: `bus_rvalid` pulses one cycle after each read, with the read data on `bus_rdata`. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| wfi_big | input | N_BIG | Standby state of each big-cluster CPU |
| wfi_lit | input | N_LIT | Standby state of each little-cluster CPU |
| irq | output | 1 | Level-high interrupt, any status flag set |
| perf_lvl_big | output | 3 | Applied big-cluster level |
| perf_lvl_lit | output | 3 | Applied little-cluster level |
| wake_mask | output | 12 | Wake-up enable mask |
| pdn_en_big | output | 1 | Big-cluster power-down enable |
| pdn_en_lit | output | 1 | Little-cluster power-down enable |
| resume_big | output | 32*N_BIG | Big-cluster resume addresses, CPU n in bits 32n+31..32n |
| resume_lit | output | 32*N_LIT | Little-cluster resume addresses, CPU n in bits 32n+31..32n |

## Verification
Each result has a fixed due time. Read data is due one cycle after the read, error flags and register writes are due on the accepting edge, and a performance change is due exactly `LAT_CYC` edges after its accepting edge. The bench drives one access per cycle on the falling edge. It counts falling edges from the accepting edge, so it samples the applied level one cycle before completion and in the completion cycle itself. It also places a status read on the very edge of a completion. Each read pushes its expected word into a scoreboard queue when it is issued, and a monitor pops and compares on every `bus_rvalid`. This ties each answer to the read that asked for it.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 8;
  localparam int MAX_LVLS  = 8;
  localparam int LVL_W     = $clog2(MAX_LVLS);
  localparam int LANE_W    = 4;
  localparam int WAKE_W    = 12;
  localparam int WAKE_LIT0 = 4;
  localparam int WAKE_GLB0 = 10;
  localparam int WFI_LIT0  = 3;

  localparam logic [ADDR_W-1:0] A_LVL_BIG = 8'h00;
  localparam logic [ADDR_W-1:0] A_LVL_LIT = 8'h08;
  localparam logic [ADDR_W-1:0] A_STATUS  = 8'h18;
  localparam logic [ADDR_W-1:0] A_WAKE    = 8'h24;
  localparam logic [ADDR_W-1:0] A_PDN_BIG = 8'h30;
  localparam logic [ADDR_W-1:0] A_PDN_LIT = 8'h34;
  localparam logic [ADDR_W-1:0] A_WFI     = 8'h3C;
  localparam logic [ADDR_W-1:0] A_MBX_BIG = 8'h68;
  localparam logic [ADDR_W-1:0] A_MBX_LIT = 8'h78;

  typedef enum logic [1:0] {
    REQ_BIG = 2'd0,
    REQ_LIT = 2'd1,
    REQ_CFG = 2'd2
  } req_kind_e;

  function automatic int done_pos(input req_kind_e k);
    return LANE_W * int'(k);
  endfunction

  function automatic int err_pos(input req_kind_e k);
    return LANE_W * int'(k) + 1;
  endfunction
endpackage

// File: rtl/cpr_perf_seq.sv
module cpr_perf_seq
  import cpr_pkg::*;
#(
  parameter int NUM_LEVELS = 5,
  parameter int LAT_CYC    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_big,
  input  logic             req_lit,
  input  logic [BUS_W-1:0] req_idx,
  input  logic             stat_clr,
  output logic [LVL_W-1:0] lvl_big,
  output logic [LVL_W-1:0] lvl_lit,
  output logic [BUS_W-1:0] stat_word,
  output logic             busy
);
  localparam int NCL   = 2;
  localparam int CNT_W = $clog2(LAT_CYC) + 1;

  logic [NCL-1:0]   req_v;
  logic             idx_ok;
  logic             accept;
  logic             finish;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_kind_q;
  logic [LVL_W-1:0] pend_idx_q;
  logic [NCL-1:0]   done_v;
  logic [NCL-1:0]   err_v;
  logic [LVL_W-1:0] lvl_v [NCL];

  assign req_v  = {req_lit, req_big};
  assign idx_ok = req_idx < BUS_W'(NUM_LEVELS);
  assign accept = (|req_v) && !busy_q && idx_ok;
  assign finish = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      pend_kind_q <= 1'b0;
      pend_idx_q  <= '0;
    end else if (accept) begin
      busy_q      <= 1'b1;
      cnt_q       <= CNT_W'(LAT_CYC - 1);
      pend_kind_q <= req_lit;
      pend_idx_q  <= req_idx[LVL_W-1:0];
    end else if (finish) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < NCL; g++) begin : g_cl
    logic             done_q;
    logic             err_q;
    logic [LVL_W-1:0] lvl_q;
    logic             done_set;
    logic             err_set;

    assign done_set = finish && (pend_kind_q == 1'(g));
    assign err_set  = req_v[g] && (busy_q || !idx_ok);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
        lvl_q  <= '0;
      end else begin
        done_q <= done_set | (done_q & ~stat_clr);
        err_q  <= err_set  | (err_q  & ~stat_clr);
        if (done_set) lvl_q <= pend_idx_q;
      end
    end

    assign done_v[g] = done_q;
    assign err_v[g]  = err_q;
    assign lvl_v[g]  = lvl_q;
  end

  always_comb begin
    stat_word = '0;
    stat_word[done_pos(REQ_BIG)] = done_v[0];
    stat_word[err_pos(REQ_BIG)]  = err_v[0];
    stat_word[done_pos(REQ_LIT)] = done_v[1];
    stat_word[err_pos(REQ_LIT)]  = err_v[1];
  end

  assign lvl_big = lvl_v[0];
  assign lvl_lit = lvl_v[1];
  assign busy    = busy_q;
endmodule

// File: rtl/cpr_cfg_regs.sv
module cpr_cfg_regs
  import cpr_pkg::*;
#(
  parameter int N_BIG = 2,
  parameter int N_LIT = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BUS_W-1:0]       wdata,
  output logic [WAKE_W-1:0]      wake_q,
  output logic                   pdn_big,
  output logic                   pdn_lit,
  output logic [N_BIG*BUS_W-1:0] mbx_big,
  output logic [N_LIT*BUS_W-1:0] mbx_lit
);
  function automatic logic [WAKE_W-1:0] wake_keep_f();
    logic [WAKE_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_BIG; i++) m[i] = 1'b1;
    for (int i = 0; i < N_LIT; i++) m[WAKE_LIT0 + i] = 1'b1;
    m[WAKE_GLB0]     = 1'b1;
    m[WAKE_GLB0 + 1] = 1'b1;
    return m;
  endfunction

  localparam logic [WAKE_W-1:0] WAKE_KEEP = wake_keep_f();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q  <= '0;
      pdn_big <= 1'b0;
      pdn_lit <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_WAKE)    wake_q  <= wdata[WAKE_W-1:0] & WAKE_KEEP;
      if (addr == A_PDN_BIG) pdn_big <= wdata[0];
      if (addr == A_PDN_LIT) pdn_lit <= wdata[0];
    end
  end

  for (genvar c = 0; c < N_BIG; c++) begin : g_mbx_big
    logic [BUS_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    word_q <= '0;
      else if (wr_en && addr == A_MBX_BIG + 8'(4*c)) word_q <= wdata;
    end
    assign mbx_big[c*BUS_W +: BUS_W] = word_q;
  end

  for (genvar c = 0; c < N_LIT; c++) begin : g_mbx_lit
    logic [BUS_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    word_q <= '0;
      else if (wr_en && addr == A_MBX_LIT + 8'(4*c)) word_q <= wdata;
    end
    assign mbx_lit[c*BUS_W +: BUS_W] = word_q;
  end
endmodule

// File: rtl/cpr_rd_mux.sv
module cpr_rd_mux
  import cpr_pkg::*;
#(
  parameter int N_BIG = 2,
  parameter int N_LIT = 3
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [LVL_W-1:0]       lvl_big,
  input  logic [LVL_W-1:0]       lvl_lit,
  input  logic [BUS_W-1:0]       stat_word,
  input  logic [WAKE_W-1:0]      wake_q,
  input  logic                   pdn_big,
  input  logic                   pdn_lit,
  input  logic [N_BIG*BUS_W-1:0] mbx_big,
  input  logic [N_LIT*BUS_W-1:0] mbx_lit,
  input  logic [N_BIG-1:0]       wfi_big,
  input  logic [N_LIT-1:0]       wfi_lit,
  output logic [BUS_W-1:0]       word
);
  logic [BUS_W-1:0] wfi_word;

  always_comb begin
    wfi_word = '0;
    for (int n = 0; n < N_BIG; n++) wfi_word[n] = wfi_big[n];
    for (int n = 0; n < N_LIT; n++) wfi_word[WFI_LIT0 + n] = wfi_lit[n];
  end

  always_comb begin
    word = '0;
    case (addr)
      A_LVL_BIG: word = BUS_W'(lvl_big);
      A_LVL_LIT: word = BUS_W'(lvl_lit);
      A_STATUS:  word = stat_word;
      A_WAKE:    word = BUS_W'(wake_q);
      A_PDN_BIG: word = BUS_W'(pdn_big);
      A_PDN_LIT: word = BUS_W'(pdn_lit);
      A_WFI:     word = wfi_word;
      default: begin
        for (int c = 0; c < N_BIG; c++)
          if (addr == A_MBX_BIG + 8'(4*c)) word = mbx_big[c*BUS_W +: BUS_W];
        for (int c = 0; c < N_LIT; c++)
          if (addr == A_MBX_LIT + 8'(4*c)) word = mbx_lit[c*BUS_W +: BUS_W];
      end
    endcase
  end
endmodule

// File: rtl/cpr_ctrl.sv
module cpr_ctrl
  import cpr_pkg::*;
#(
  parameter int N_BIG      = 2,
  parameter int N_LIT      = 3,
  parameter int NUM_LEVELS = 5,
  parameter int LAT_CYC    = 250000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_en,
  input  logic                   bus_we,
  input  logic [7:0]             bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic                   bus_rvalid,
  output logic [31:0]            bus_rdata,
  input  logic [N_BIG-1:0]       wfi_big,
  input  logic [N_LIT-1:0]       wfi_lit,
  output logic                   irq,
  output logic [2:0]             perf_lvl_big,
  output logic [2:0]             perf_lvl_lit,
  output logic [11:0]            wake_mask,
  output logic                   pdn_en_big,
  output logic                   pdn_en_lit,
  output logic [N_BIG*32-1:0]    resume_big,
  output logic [N_LIT*32-1:0]    resume_lit
);
  logic             wr_en;
  logic             rd_en;
  logic             req_big;
  logic             req_lit;
  logic             stat_clr;
  logic [BUS_W-1:0] stat_word;
  logic             seq_busy;
  logic [BUS_W-1:0] rd_word;

  assign wr_en    = bus_en && bus_we;
  assign rd_en    = bus_en && !bus_we;
  assign req_big  = wr_en && (bus_addr == A_LVL_BIG);
  assign req_lit  = wr_en && (bus_addr == A_LVL_LIT);
  assign stat_clr = rd_en && (bus_addr == A_STATUS);

  cpr_perf_seq #(
    .NUM_LEVELS(NUM_LEVELS),
    .LAT_CYC   (LAT_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_big  (req_big),
    .req_lit  (req_lit),
    .req_idx  (bus_wdata),
    .stat_clr (stat_clr),
    .lvl_big  (perf_lvl_big),
    .lvl_lit  (perf_lvl_lit),
    .stat_word(stat_word),
    .busy     (seq_busy)
  );

  cpr_cfg_regs #(
    .N_BIG(N_BIG),
    .N_LIT(N_LIT)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .wake_q (wake_mask),
    .pdn_big(pdn_en_big),
    .pdn_lit(pdn_en_lit),
    .mbx_big(resume_big),
    .mbx_lit(resume_lit)
  );

  cpr_rd_mux #(
    .N_BIG(N_BIG),
    .N_LIT(N_LIT)
  ) u_mux (
    .addr     (bus_addr),
    .lvl_big  (perf_lvl_big),
    .lvl_lit  (perf_lvl_lit),
    .stat_word(stat_word),
    .wake_q   (wake_mask),
    .pdn_big  (pdn_en_big),
    .pdn_lit  (pdn_en_lit),
    .mbx_big  (resume_big),
    .mbx_lit  (resume_lit),
    .wfi_big  (wfi_big),
    .wfi_lit  (wfi_lit),
    .word     (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_word;
    end
  end

  assign irq = |stat_word;
endmodule

// File: rtl/cpr_ctrl_chk.sv
module cpr_ctrl_chk #(
  parameter int NUM_LEVELS = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en,
  input logic        bus_we,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        irq,
  input logic [2:0]  perf_lvl_big,
  input logic [2:0]  perf_lvl_lit,
  input logic [11:0] wake_mask,
  input logic [31:0] stat_word,
  input logic        seq_busy
);
  // R2
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(perf_lvl_big) < NUM_LEVELS) && (32'(perf_lvl_lit) < NUM_LEVELS));

  // R2
  lvl_step_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(perf_lvl_big) |-> stat_word[0]);

  // R3
  bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && bus_en && bus_we && bus_addr == 8'h08 && bus_wdata >= 32'(NUM_LEVELS))
    |=> ($stable(perf_lvl_lit) && stat_word[5]));

  // R4
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && bus_en && bus_we && bus_addr == 8'h00) |=> stat_word[1]);

  // R5
  clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 8'h18 && !seq_busy) |=> !irq);

  // R5
  lane_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word & ~32'h0000_0033) == 32'h0);

  // R6
  wake_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_mask[9:8] == 2'b00);
endmodule

bind cpr_ctrl cpr_ctrl_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en      (bus_en),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .irq         (irq),
  .perf_lvl_big(perf_lvl_big),
  .perf_lvl_lit(perf_lvl_lit),
  .wake_mask   (wake_mask),
  .stat_word   (stat_word),
  .seq_busy    (seq_busy)
);

// File: tb/test_cpr_ctrl.sv
`timescale 1ns/1ps
module test_cpr_ctrl;
  localparam int LAT = 20;
  localparam int NLV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [1:0]  wfi_big = '0;
  logic [2:0]  wfi_lit = '0;
  logic        irq;
  logic [2:0]  perf_lvl_big, perf_lvl_lit;
  logic [11:0] wake_mask;
  logic        pdn_en_big, pdn_en_lit;
  logic [63:0] resume_big;
  logic [95:0] resume_lit;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cpr_ctrl #(.N_BIG(2), .N_LIT(3), .NUM_LEVELS(NLV), .LAT_CYC(LAT)) i_cpr_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .wfi_big(wfi_big), .wfi_lit(wfi_lit), .irq(irq),
    .perf_lvl_big(perf_lvl_big), .perf_lvl_lit(perf_lvl_lit),
    .wake_mask(wake_mask), .pdn_en_big(pdn_en_big), .pdn_en_lit(pdn_en_lit),
    .resume_big(resume_big), .resume_lit(resume_lit));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, access sampled at the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  // monitor: pops one expected word per returned read
  always @(negedge clk) begin : mon
    logic [31:0] e;
    string t;
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unrequested read data actual %h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata, e, t);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk({31'b0, irq}, 32'h0, "R1 irq");
    chk({29'b0, perf_lvl_big}, 32'h0, "R1 big level port");
    chk({20'b0, wake_mask}, 32'h0, "R1 wake port");
    chk(resume_lit[31:0], 32'h0, "R1 mailbox port");
    rd(8'h00, 32'h0, "R1 big level");
    rd(8'h08, 32'h0, "R1 little level");
    rd(8'h18, 32'h0, "R1 status");
    rd(8'h24, 32'h0, "R1 wake");
    rd(8'h30, 32'h0, "R1 pdn");
    rd(8'h68, 32'h0, "R1 mailbox");

    // R2 big request timing
    wr(8'h00, 32'd3);
    repeat (LAT - 1) @(negedge clk);
    chk({29'b0, perf_lvl_big}, 32'd0, "R2 level before due edge");
    chk({31'b0, irq}, 32'h0, "R2 irq before due edge");
    @(negedge clk);
    chk({29'b0, perf_lvl_big}, 32'd3, "R2 level on due edge");
    chk({31'b0, irq}, 32'h1, "R5 irq with done flag");
    rd(8'h18, 32'h1, "R2 big done flag");
    chk({31'b0, irq}, 32'h0, "R5 irq after clear");
    rd(8'h18, 32'h0, "R5 cleared status");
    rd(8'h00, 32'd3, "R2 big level readback");

    // R2 little request at top valid index
    wr(8'h08, 32'd4);
    repeat (LAT) @(negedge clk);
    rd(8'h08, 32'd4, "R2 little level readback");
    rd(8'h18, 32'h10, "R2 little done flag");

    // R3 out-of-range indices
    wr(8'h00, NLV);
    chk({31'b0, irq}, 32'h1, "R3 error irq on accepting edge");
    chk({29'b0, perf_lvl_big}, 32'd3, "R3 big level unchanged");
    rd(8'h18, 32'h2, "R3 big error flag");
    wr(8'h08, 32'd7);
    rd(8'h18, 32'h20, "R3 little error flag");
    wr(8'h00, 32'h100);
    rd(8'h18, 32'h2, "R3 upper data bits count");
    chk({29'b0, perf_lvl_lit}, 32'd4, "R3 little level unchanged");

    // R4 writes while busy
    wr(8'h00, 32'd1);
    wr(8'h08, 32'd2);
    wr(8'h00, 32'd0);
    repeat (LAT - 3) @(negedge clk);
    chk({29'b0, perf_lvl_big}, 32'd3, "R4 level before completion");
    @(negedge clk);
    chk({29'b0, perf_lvl_big}, 32'd1, "R4 first request completes");
    chk({29'b0, perf_lvl_lit}, 32'd4, "R4 ignored little write");
    rd(8'h18, 32'h23, "R4 done plus both errors");

    // R5 flag setting on the clearing edge survives
    wr(8'h00, 32'd2);
    repeat (LAT - 1) @(negedge clk);
    rd(8'h18, 32'h0, "R5 read on completion edge");
    chk({31'b0, irq}, 32'h1, "R5 irq kept after same-edge set");
    rd(8'h18, 32'h1, "R5 surviving done flag");

    // R4 write on the completing edge is rejected
    wr(8'h08, 32'd1);
    repeat (LAT - 1) @(negedge clk);
    wr(8'h08, 32'd3);
    chk({29'b0, perf_lvl_lit}, 32'd1, "R4 completion applied");
    rd(8'h18, 32'h30, "R4 done and error same edge");
    rd(8'h08, 32'd1, "R4 level not retargeted");

    // R6 wake mask
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, 32'h0000_0C73, "R6 wake mask writable bits");
    chk({20'b0, wake_mask}, 32'h0000_0C73, "R6 wake port");
    wr(8'h24, 32'h0000_0412);
    rd(8'h24, 32'h0000_0412, "R6 wake pattern");

    // R7 power-down enables
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h34, 32'h0000_0002);
    rd(8'h30, 32'h1, "R7 big pdn");
    rd(8'h34, 32'h0, "R7 little pdn bit1 dropped");
    chk({30'b0, pdn_en_big, pdn_en_lit}, 32'h2, "R7 pdn ports");

    // R8 mailboxes
    wr(8'h68, 32'hA000_0000);
    wr(8'h6C, 32'hA000_1004);
    wr(8'h78, 32'hB000_0010);
    wr(8'h80, 32'hB000_2020);
    wr(8'h70, 32'hDEAD_BEEF);
    rd(8'h6C, 32'hA000_1004, "R8 big cpu1");
    rd(8'h80, 32'hB000_2020, "R8 little cpu2");
    rd(8'h7C, 32'h0, "R8 little cpu1 untouched");
    rd(8'h70, 32'h0, "R8 beyond big count");
    chk(resume_big[63:32], 32'hA000_1004, "R8 big port slice");
    chk(resume_lit[31:0], 32'hB000_0010, "R8 little port slice");

    // R9 standby word
    wfi_big = 2'b10;
    wfi_lit = 3'b101;
    rd(8'h3C, 32'h0000_002A, "R9 standby layout");
    wr(8'h3C, 32'hFFFF_FFFF);
    wfi_big = 2'b01;
    wfi_lit = 3'b010;
    rd(8'h3C, 32'h0000_0011, "R9 read-only after write");

    // R10 unmapped
    rd(8'h50, 32'h0, "R10 unmapped address");
    @(negedge clk);
    chk(32'(exp_q.size()), 32'h0, "R10 every read answered");

    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule